// File: doc/BRIEF.md
# Two-Wire Bus Master with Event Status Codes

This block is a byte-level master for a two-wire serial bus with open-drain clock and data lines. Software controls it through a control register, a data register and a status register. Software requests a START or a STOP by setting control bits. It puts either an address byte or a data byte into the data register. The block then runs the bus operation that the current phase calls for. A repeated START is a START issued while the master still owns the bus.

When each START, address byte or data byte finishes, the block raises an event flag. It also posts an 8-bit status code that tells software what happened: the acknowledge it saw, the acknowledge it sent, or a lost arbitration. While the flag is set the master holds SCL low and the bus waits. Writing 1 to the flag bit clears it and lets the next operation start. A STOP completes quietly and raises no flag. The bus clock comes from a fixed divider set by a parameter. Each bit lasts four divider ticks: SCL is low for two ticks and high for two.

The lines are modelled as separate pull-low enables (`scl_oe`, `sda_oe`) and sensed inputs (`scl_in`, `sda_in`). The master checks its own transmitted 1 bits against the data line. If it finds one held low by another driver, it gives up the bus.

Top module: `twi_master`

## Requirements
- R1: After reset the status reads 8'hF8, the flag (control bit 7) is low, the control register reads 8'h00 and neither line is pulled low.
- R2: The flag is set after each completed START, address or data byte, and writing a control word with bit 7 = 1 clears it. While the flag is set and the bus is owned, SCL stays held low and the status does not change.
- R3: Control bit 5 requests a START. It clears itself once the START is issued. It posts 8'h08 when the bus was free and 8'h10 when the master already owned the bus.
- R4: An address byte with bit 0 = 0 (write) posts 8'h18 when the slave acknowledges and 8'h20 when it does not.
- R5: The data register holds the 7-bit slave address in bits 7..1 and the direction in bit 0, where 1 means read. A read address byte posts 8'h40 when acknowledged and 8'h48 when not. After a repeated START, either direction may be chosen.
- R6: In write direction each data byte is sent MSB first. The status is 8'h28 when the slave acknowledges and 8'h30 when it does not.
- R7: In read direction the received byte appears in the data register. Control bit 6 = 1 makes the master return ACK and post 8'h50. With bit 6 = 0 it returns NACK and posts 8'h58.
- R8: Suppose the master releases SDA for a 1 bit of an address or data byte and senses it low while SCL is high. The master then releases both lines, posts 8'h38 and raises the flag.
- R9: A data-register write while the flag is low is discarded and sets control bit 3 (collision). A data-register write while the flag is high loads the byte and clears bit 3.
- R10: Control bit 4 requests a STOP. It drives a STOP condition, then bit 4 clears itself, the status returns to 8'hF8, the flag stays low and both lines are released.
- R11: Every SCL high pulse within a byte lasts exactly 2*DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| data_we | input | 1 | Write strobe for the data register |
| wdata | input | 8 | Write data for either register |
| ctrl_rdata | output | 8 | Control register: {flag, ack enable, start, stop, collision, 3'b0} |
| data_rdata | output | 8 | Data register contents |
| status | output | 8 | Status code of the last event |
| irq | output | 1 | Event flag, mirrors control bit 7 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The bench puts a behavioural slave and a rival driver on the wired lines. The first corner case is the repeated START: if ownership is tracked wrongly, the design posts 8'h08 where 8'h10 belongs, or it drops SCL and the slave sees a stray STOP. The second is a data write made while the flag is low: a design that accepts it sends the wrong address and leaves the collision bit clear. The last read byte is NACKed. A design that ignores the acknowledge-enable bit keeps the slave driving and posts 8'h50 instead of 8'h58. The bench also forces arbitration loss on the first address bit, where a faulty design keeps pulling the lines or reports an address status instead of 8'h38.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WRITE, CMD_READ} cmd_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_WR, PH_RD} phase_e;
  typedef enum logic [2:0] {ACT_NONE, ACT_START, ACT_STOP, ACT_ADDR, ACT_WR, ACT_RD} act_e;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_DW_NACK = 8'h30;
  localparam logic [7:0] ST_LOST    = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  localparam int CB_FLAG  = 7;
  localparam int CB_ACKEN = 6;
  localparam int CB_STA   = 5;
  localparam int CB_STO   = 4;
  localparam int CB_WCOL  = 3;

  // status for a finished action; ack is the bit seen (or sent, for reads)
  function automatic logic [7:0] event_code(act_e a, logic rep, logic ack, logic rd);
    case (a)
      ACT_START: return rep ? ST_RESTART : ST_START;
      ACT_ADDR:  return rd ? (ack ? ST_AR_ACK : ST_AR_NACK) : (ack ? ST_AW_ACK : ST_AW_NACK);
      ACT_WR:    return ack ? ST_DW_ACK : ST_DW_NACK;
      ACT_RD:    return ack ? ST_DR_ACK : ST_DR_NACK;
      default:   return ST_IDLE;
    endcase
  endfunction

  function automatic cmd_e cmd_for(act_e a);
    case (a)
      ACT_START: return CMD_START;
      ACT_STOP:  return CMD_STOP;
      ACT_RD:    return CMD_READ;
      default:   return CMD_WRITE;
    endcase
  endfunction

endpackage

// File: rtl/twi_tick.sv
module twi_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (cnt == CW'(DIV - 1))    cnt <= '0;
        else                             cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/twi_bitengine.sv
module twi_bitengine
  import twi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  cmd_e       cmd,
  input  logic [7:0] tx_byte,
  input  logic       ack_send,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       busy,
  output logic       own,
  output logic       done,
  output logic       lost,
  output logic       ack_in,
  output logic [7:0] rx_byte,
  output logic       scl_oe,
  output logic       sda_oe
);
  cmd_e       cmd_q;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       ack_q;

  // quarter 1 waits for SCL to actually read high
  logic adv, is_byte, samp, arb_hit;
  assign adv     = busy && tick && !(q == 2'd1 && !scl_in);
  assign is_byte = (cmd_q == CMD_WRITE) || (cmd_q == CMD_READ);
  assign samp    = adv && (q == 2'd1) && is_byte;
  assign arb_hit = samp && (cmd_q == CMD_WRITE) && (bitn < 4'd8) && sh[7] && !sda_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; own <= 1'b0; done <= 1'b0; lost <= 1'b0; ack_in <= 1'b0;
      cmd_q <= CMD_START; q <= 2'd0; bitn <= 4'd0; sh <= 8'h00; rx_byte <= 8'h00;
      ack_q <= 1'b0;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1; cmd_q <= cmd; q <= 2'd0; bitn <= 4'd0;
          sh <= tx_byte; ack_q <= ack_send;
        end
      end else if (arb_hit) begin
        busy <= 1'b0; own <= 1'b0; done <= 1'b1; lost <= 1'b1;
      end else if (adv) begin
        q <= q + 2'd1;
        if (samp) begin
          if (bitn == 4'd8)            ack_in  <= !sda_in;
          else if (cmd_q == CMD_READ)  rx_byte <= {rx_byte[6:0], sda_in};
        end
        if (q == 2'd3) begin
          if (!is_byte) begin
            busy <= 1'b0; done <= 1'b1; own <= (cmd_q == CMD_START);
          end else if (bitn == 4'd8) begin
            busy <= 1'b0; done <= 1'b1;
          end else begin
            bitn <= bitn + 4'd1;
            sh   <= {sh[6:0], 1'b1};
          end
        end
      end
    end
  end

  always_comb begin
    scl_oe = own;
    sda_oe = 1'b0;
    if (busy) begin
      case (cmd_q)
        CMD_START: begin
          scl_oe = (q == 2'd0) ? own : (q == 2'd3);
          sda_oe = q[1];
        end
        CMD_STOP: begin
          scl_oe = (q == 2'd0);
          sda_oe = (q != 2'd3);
        end
        default: begin
          scl_oe = (q == 2'd0) || (q == 2'd3);
          sda_oe = (cmd_q == CMD_WRITE) ? !sh[7] : ((bitn == 4'd8) && ack_q);
        end
      endcase
    end
  end
endmodule

// File: rtl/twi_master.sv
module twi_master
  import twi_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_rdata,
  output logic [7:0] data_rdata,
  output logic [7:0] status,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic       flag, acken, sta, sto, wcol, pend;
  logic       rep_q, rd_q, ack_sent_q;
  logic [7:0] data_q, status_q;
  phase_e     phase;
  act_e       act_q, nxt_act;

  logic       tick, eng_go, eng_busy, eng_own, eng_done, eng_lost, eng_ack, launch;
  logic [7:0] eng_rx;

  twi_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  always_comb begin
    nxt_act = ACT_NONE;
    if (sto)      nxt_act = ACT_STOP;
    else if (sta) nxt_act = ACT_START;
    else begin
      case (phase)
        PH_ADDR: nxt_act = ACT_ADDR;
        PH_WR:   nxt_act = ACT_WR;
        PH_RD:   nxt_act = ACT_RD;
        default: nxt_act = ACT_NONE;
      endcase
    end
  end

  assign launch = pend && !flag && !eng_busy && !eng_done;
  assign eng_go = launch && (nxt_act != ACT_NONE);

  twi_bitengine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(eng_go), .cmd(cmd_for(nxt_act)),
    .tx_byte(data_q), .ack_send(acken), .scl_in(scl_in), .sda_in(sda_in),
    .busy(eng_busy), .own(eng_own), .done(eng_done), .lost(eng_lost),
    .ack_in(eng_ack), .rx_byte(eng_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0; acken <= 1'b0; sta <= 1'b0; sto <= 1'b0; wcol <= 1'b0; pend <= 1'b0;
      rep_q <= 1'b0; rd_q <= 1'b0; ack_sent_q <= 1'b0;
      data_q <= 8'h00; status_q <= ST_IDLE; phase <= PH_IDLE; act_q <= ACT_NONE;
    end else begin
      if (ctrl_we) begin
        acken <= wdata[CB_ACKEN];
        sta   <= wdata[CB_STA];
        sto   <= wdata[CB_STO];
        if (wdata[CB_FLAG]) flag <= 1'b0;
        if (wdata[CB_FLAG] || !flag) pend <= 1'b1;
      end else if (launch) begin
        pend <= 1'b0;
      end

      if (eng_go) begin
        act_q      <= nxt_act;
        rep_q      <= eng_own;
        ack_sent_q <= acken;
        if (nxt_act == ACT_START) sta  <= 1'b0;
        if (nxt_act == ACT_ADDR)  rd_q <= data_q[0];
      end

      if (data_we) begin
        if (flag) begin
          data_q <= wdata;
          wcol   <= 1'b0;
        end else begin
          wcol   <= 1'b1;
        end
      end

      if (eng_done) begin
        if (eng_lost) begin
          status_q <= ST_LOST; flag <= 1'b1; phase <= PH_IDLE;
        end else if (act_q == ACT_STOP) begin
          status_q <= ST_IDLE; sto <= 1'b0; phase <= PH_IDLE;
        end else begin
          status_q <= event_code(act_q, rep_q, (act_q == ACT_RD) ? ack_sent_q : eng_ack, rd_q);
          flag     <= 1'b1;
          case (act_q)
            ACT_START: phase  <= PH_ADDR;
            ACT_ADDR:  phase  <= rd_q ? PH_RD : PH_WR;
            ACT_RD:    data_q <= eng_rx;
            default: ;
          endcase
        end
      end
    end
  end

  assign ctrl_rdata = {flag, acken, sta, sto, wcol, 3'b000};
  assign data_rdata = data_q;
  assign status     = status_q;
  assign irq        = flag;
endmodule

// File: rtl/twi_master_chk.sv
module twi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       ctrl_we,
  input logic       data_we,
  input logic [7:0] ctrl_rdata,
  input logic [7:0] status,
  input logic       eng_busy,
  input logic       eng_own,
  input logic       eng_lost,
  input logic       tick
);
  // R2
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !eng_busy);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && eng_own) |-> scl_oe);

  // R8
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_lost |-> (!scl_oe && !sda_oe));

  // R8
  lost_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_lost |=> (irq && status == 8'h38));

  // R9
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !irq) |=> ctrl_rdata[3]);

  // R10
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_rdata[4]) && !$past(ctrl_we)) |-> (!irq && status == 8'hF8 && !scl_oe && !sda_oe));

  // R11
  scl_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !tick) |=> $stable(scl_oe));
endmodule

bind twi_master twi_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ctrl_we(ctrl_we), .data_we(data_we), .ctrl_rdata(ctrl_rdata), .status(status),
  .eng_busy(eng_busy), .eng_own(eng_own), .eng_lost(eng_lost), .tick(tick)
);

// File: tb/tb_twi_master.sv
module tb_twi_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, data_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] ctrl_rdata, data_rdata, status;
  logic irq, scl_oe, sda_oe, scl, sda;

  logic s_drive = 1'b0, rival = 1'b0, s_nack = 1'b0;
  logic [7:0] rd_bytes [0:7];

  assign scl = !scl_oe;
  assign sda = !(sda_oe || s_drive || rival);

  always #(CLK_PERIOD/2) clk = !clk;

  twi_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .data_we(data_we), .wdata(wdata),
    .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata), .status(status), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl), .sda_oe(sda_oe), .sda_in(sda)
  );

  // behavioural slave on the wired bus
  logic sp_scl = 1'b1, sp_sda = 1'b1;
  logic s_act = 1'b0, s_adr = 1'b0, s_rd = 1'b0, s_match = 1'b0, s_mack = 1'b0;
  logic [3:0] s_bit = 4'd0;
  logic [7:0] s_sh = 8'h00, s_txsh = 8'hFF, s_got = 8'h00;
  logic [2:0] s_ridx = 3'd0;
  int s_stops = 0;

  always @(negedge clk) begin
    sp_scl <= scl;
    sp_sda <= sda;
    if (!rst_n) begin
      s_act <= 1'b0; s_drive <= 1'b0;
    end else if (sp_scl && scl && sp_sda && !sda) begin
      s_act <= 1'b1; s_adr <= 1'b1; s_rd <= 1'b0; s_bit <= 4'hF; s_drive <= 1'b0; s_ridx <= 3'd0;
    end else if (sp_scl && scl && !sp_sda && sda) begin
      s_act <= 1'b0; s_drive <= 1'b0; s_stops <= s_stops + 1;
    end else if (s_act && !sp_scl && scl) begin
      if (s_bit < 4'd8)               s_sh   <= {s_sh[6:0], sda};
      else if (s_bit == 4'd8 && s_rd && !s_adr) s_mack <= !sda;
    end else if (s_act && sp_scl && !scl) begin
      if (s_bit == 4'hF) begin
        s_bit <= 4'd0;
      end else if (s_bit == 4'd7) begin
        s_bit <= 4'd8;
        if (s_adr) begin
          s_match <= (s_sh[7:1] == SLV);
          s_drive <= (s_sh[7:1] == SLV);
          s_rd    <= s_sh[0];
        end else if (!s_rd) begin
          s_got   <= s_sh;
          s_drive <= !s_nack;
        end else begin
          s_drive <= 1'b0;
        end
      end else if (s_bit == 4'd8) begin
        s_bit <= 4'd0;
        s_adr <= 1'b0;
        if (!s_match || (s_rd && !s_adr && !s_mack)) begin
          s_act <= 1'b0; s_drive <= 1'b0;
        end else if (s_rd) begin
          s_drive <= !rd_bytes[s_ridx][7];
          s_txsh  <= {rd_bytes[s_ridx][6:0], 1'b1};
          s_ridx  <= s_ridx + 3'd1;
        end else begin
          s_drive <= 1'b0;
        end
      end else begin
        s_bit <= s_bit + 4'd1;
        if (s_rd && !s_adr) begin
          s_drive <= !s_txsh[7];
          s_txsh  <= {s_txsh[6:0], 1'b1};
        end
      end
    end
  end

  // width of the last completed SCL high pulse
  int hi_run = 0, hi_w = 0;
  always @(negedge clk) begin
    if (scl) hi_run <= hi_run + 1;
    else begin
      if (hi_run != 0) hi_w <= hi_run;
      hi_run <= 0;
    end
  end

  int n_chk = 0, n_err = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected status codes, restated from the requirements
  function automatic logic [7:0] want(input string kind, input bit ack);
    if (kind == "aw") return ack ? 8'h18 : 8'h20;
    if (kind == "ar") return ack ? 8'h40 : 8'h48;
    if (kind == "dw") return ack ? 8'h28 : 8'h30;
    if (kind == "dr") return ack ? 8'h50 : 8'h58;
    return 8'hF8;
  endfunction

  task automatic ctrl_write(input logic [7:0] v);
    ctrl_we = 1'b1; wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] v);
    data_we = 1'b1; wdata = v;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk(irq, req, 32'(irq), 32'd1);
  endtask

  task automatic wait_stop(input string req);
    int n = 0;
    while (ctrl_rdata[4] && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(!ctrl_rdata[4], req, 32'(ctrl_rdata[4]), 32'd0);
  endtask

  // global watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    bit ack;
    int stops_before;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) rd_bytes[i] = 8'($urandom);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(ctrl_rdata == 8'h00 && !irq, "R1 control", ctrl_rdata, 8'h00);
    chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);

    // R3 plain START
    ctrl_write(8'h20);
    wait_irq("R3 start flag");
    chk(status == 8'h08, "R3 start code", status, 8'h08);
    chk(!ctrl_rdata[5], "R3 start bit self-clears", ctrl_rdata[5], 0);

    // R2 stall while flag is set
    repeat (60) @(negedge clk);
    chk(irq && scl_oe && status == 8'h08, "R2 stall", {irq, scl_oe, status}, {2'b11, 8'h08});

    // R4 SLA+W, plus R9 collision during the transfer
    data_write({SLV, 1'b0});
    ctrl_write(8'h80);
    chk(!irq, "R2 flag cleared by 1", irq, 0);
    data_write(8'h55);
    chk(data_rdata == {SLV, 1'b0}, "R9 write discarded", data_rdata, {SLV, 1'b0});
    chk(ctrl_rdata[3], "R9 collision set", ctrl_rdata[3], 1);
    wait_irq("R4 flag");
    chk(status == want("aw", 1), "R4 addr write ack", status, want("aw", 1));

    // R6 random data bytes with random slave acknowledge, R11 pulse width
    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom);
      ack = (i == 0) ? 1'b1 : ($urandom % 3 != 0);
      s_nack = !ack;
      data_write(b);
      if (i == 0) chk(!ctrl_rdata[3], "R9 collision cleared", ctrl_rdata[3], 0);
      ctrl_write(8'h80);
      wait_irq("R6 flag");
      chk(status == want("dw", ack), "R6 data write code", status, want("dw", ack));
      chk(s_got == b, "R6 byte on bus", s_got, b);
      if (i == 0) chk(hi_w == 2 * DIV, "R11 scl high width", hi_w, 2 * DIV);
    end
    s_nack = 1'b0;

    // R3 repeated START, R5 direction switch to read
    ctrl_write(8'hA0);
    wait_irq("R3 restart flag");
    chk(status == 8'h10, "R3 restart code", status, 8'h10);
    data_write({SLV, 1'b1});
    ctrl_write(8'h80);
    wait_irq("R5 flag");
    chk(status == want("ar", 1), "R5 addr read ack", status, want("ar", 1));

    // R7 reads: ACK on all but the last
    for (int i = 0; i < 5; i++) begin
      ack = (i < 4);
      ctrl_write(ack ? 8'hC0 : 8'h80);
      wait_irq("R7 flag");
      chk(status == want("dr", ack), "R7 read code", status, want("dr", ack));
      chk(data_rdata == rd_bytes[i], "R7 read byte", data_rdata, rd_bytes[i]);
    end

    // R10 STOP
    stops_before = s_stops;
    ctrl_write(8'h90);
    wait_stop("R10 stop bit clears");
    chk(!irq && status == 8'hF8, "R10 quiet stop", {irq, status}, 9'h0F8);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    chk(s_stops == stops_before + 1, "R10 stop seen on bus", s_stops, stops_before + 1);

    // R5 and R4 with an address nobody answers
    ctrl_write(8'h20);
    wait_irq("R3 start flag 2");
    chk(status == 8'h08, "R3 start after stop", status, 8'h08);
    data_write({7'h11, 1'b1});
    ctrl_write(8'h80);
    wait_irq("R5 flag 2");
    chk(status == want("ar", 0), "R5 addr read nack", status, want("ar", 0));
    ctrl_write(8'hA0);
    wait_irq("R3 restart flag 2");
    chk(status == 8'h10, "R3 restart after nack", status, 8'h10);
    data_write({7'h11, 1'b0});
    ctrl_write(8'h80);
    wait_irq("R4 flag 2");
    chk(status == want("aw", 0), "R4 addr write nack", status, want("aw", 0));
    ctrl_write(8'h90);
    wait_stop("R10 stop 2");

    // R8 arbitration loss on the first address bit
    ctrl_write(8'h20);
    wait_irq("R3 start flag 3");
    data_write(8'hFE);
    rival = 1'b1;
    ctrl_write(8'h80);
    wait_irq("R8 flag");
    chk(status == 8'h38, "R8 lost code", status, 8'h38);
    chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
    repeat (4) @(negedge clk);
    rival = 1'b0;
    repeat (4) @(negedge clk);
    ctrl_write(8'h90);
    wait_stop("R10 stop after loss");
    chk(!irq && status == 8'hF8, "R10 status after loss", {irq, status}, 9'h0F8);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule